// File: doc/BRIEF.md
# CSR Instruction Execution Unit

This unit carries out the six control-and-status register instructions (read-and-write, read-and-set, read-and-clear, each in a register-operand and an immediate-operand form) against a CSR file attached to it. It holds one instruction at a time. An instruction arrives with its operation code, destination tag, source tag or ready source value, source register index, 5-bit immediate, 12-bit CSR address and reorder-buffer id. If the source value is not yet available, the unit takes it from the result-broadcast port when the broadcast tag matches.

The unit does not touch any CSR state until a precommit indication carrying its reorder-buffer id has arrived. It then checks the access in one cycle and performs the read-modify-write in that same cycle. The access check covers presence, privilege, read-only space and counter enables. The unit then holds the old CSR value, or an exception flag, on the result port until that port is accepted.

An illegal access performs no write. It pulses the exception port with the reorder-buffer id, the illegal-instruction cause and a zero pc.

Top module: `csr_exec_unit`

## Requirements
- R1: Operation codes on `issue_op` are 1 = read-write, 2 = read-set, 3 = read-clear, 5 = read-write immediate, 6 = read-set immediate and 7 = read-clear immediate. The write-form codes store the operand unchanged. The set-form codes store old OR operand. The clear-form codes store old AND NOT operand.
- R2: The immediate codes (bit 2 of `issue_op` set) use `issue_imm` zero-extended to XLEN as the operand and ignore `issue_src_val`. The register codes use the source value.
- R3: Read-set and read-clear perform no write when `issue_rs1_idx` is 0. Their immediate forms perform no write when the immediate is 0. The old value is still returned.
- R4: The result port returns the CSR value from before the write, together with the destination tag. `res_valid` and the result fields stay stable until `res_ready` is high.
- R5: When `issue_src_tag` is nonzero, the operand is taken from the first broadcast after acceptance whose `bcast_tag` equals that tag. Broadcasts with other tags are ignored.
- R6: No CSR write happens before a `precommit_valid` cycle whose `precommit_rob` equals the instruction's reorder-buffer id. A precommit carrying another id has no effect.
- R7: A write to an address whose bits [11:10] are 11 is illegal. A pure read of such an address is legal.
- R8: An access to an address for which `csr_present` is low is illegal.
- R9: An access is illegal when address bits [9:8] exceed `priv` (0 = user, 1 = supervisor, 3 = machine).
- R10: Addresses 0xC00 (cycle, enable bit 0) and 0xC01 (time, enable bit 1) are governed by the enable bits:
  - machine mode is always allowed;
  - supervisor mode needs the bit set in `cnt_m_en`;
  - user mode needs the bit set in both `cnt_m_en` and `cnt_s_en`.
- R11: An illegal access returns `res_exc` = 1 with `res_value` 0 and performs no CSR write. It pulses `exc_valid` for one cycle with `exc_rob` = the id, `exc_cause` = 2 and `exc_pc` = 0. A legal access never pulses `exc_valid`.
- R12: `issue_ready` is high only when no instruction is held. It drops in the cycle after an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit is empty and takes the instruction |
| issue_op | input | 3 | Operation code (see R1) |
| issue_dst_tag | input | TAGW | Destination tag |
| issue_src_tag | input | TAGW | Source tag, 0 when the value is ready |
| issue_src_val | input | XLEN | Ready source value |
| issue_rs1_idx | input | 5 | Source register index |
| issue_imm | input | 5 | Immediate operand |
| issue_addr | input | 12 | CSR address |
| issue_rob | input | ROBW | Reorder-buffer id |
| bcast_valid | input | 1 | Result broadcast valid |
| bcast_tag | input | TAGW | Broadcast tag |
| bcast_val | input | XLEN | Broadcast value |
| precommit_valid | input | 1 | Precommit indication |
| precommit_rob | input | ROBW | Id allowed to take effect |
| priv | input | 2 | Current privilege level |
| cnt_m_en | input | 2 | Machine-level counter enables (bit 0 cycle, bit 1 time) |
| cnt_s_en | input | 2 | Supervisor-level counter enables |
| csr_addr | output | 12 | Address to the CSR file |
| csr_present | input | 1 | A CSR exists at `csr_addr` |
| csr_rdata | input | XLEN | Current value at `csr_addr` |
| csr_we | output | 1 | Write strobe |
| csr_wdata | output | XLEN | Write value |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_dst_tag | output | TAGW | Destination tag of the result |
| res_value | output | XLEN | Old CSR value |
| res_exc | output | 1 | Exception flag |
| exc_valid | output | 1 | Exception report pulse |
| exc_rob | output | ROBW | Reorder-buffer id of the faulting instruction |
| exc_cause | output | 4 | Cause code, 2 = illegal instruction |
| exc_pc | output | XLEN | Faulting pc, always 0 |

## Verification
The assertions assume that the attached CSR file answers `csr_present` and `csr_rdata` combinationally from `csr_addr`. They also assume that a precommit for an instruction is only sent after that instruction has been accepted. The assertions use their own record of the accepted id to tie every write strobe to a matching precommit. The bench keeps within these assumptions in two ways. Its CSR model is a purely combinational lookup over a handful of addresses. Each task raises the precommit only after the issue handshake and any broadcasts, first with a wrong id and only later with the right one.

// File: rtl/csr_exec_unit.sv
module csr_exec_unit #(
  parameter int XLEN = 32,
  parameter int TAGW = 4,
  parameter int ROBW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [2:0]      issue_op,
  input  logic [TAGW-1:0] issue_dst_tag,
  input  logic [TAGW-1:0] issue_src_tag,
  input  logic [XLEN-1:0] issue_src_val,
  input  logic [4:0]      issue_rs1_idx,
  input  logic [4:0]      issue_imm,
  input  logic [11:0]     issue_addr,
  input  logic [ROBW-1:0] issue_rob,
  input  logic            bcast_valid,
  input  logic [TAGW-1:0] bcast_tag,
  input  logic [XLEN-1:0] bcast_val,
  input  logic            precommit_valid,
  input  logic [ROBW-1:0] precommit_rob,
  input  logic [1:0]      priv,
  input  logic [1:0]      cnt_m_en,
  input  logic [1:0]      cnt_s_en,
  output logic [11:0]     csr_addr,
  input  logic            csr_present,
  input  logic [XLEN-1:0] csr_rdata,
  output logic            csr_we,
  output logic [XLEN-1:0] csr_wdata,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [TAGW-1:0] res_dst_tag,
  output logic [XLEN-1:0] res_value,
  output logic            res_exc,
  output logic            exc_valid,
  output logic [ROBW-1:0] exc_rob,
  output logic [3:0]      exc_cause,
  output logic [XLEN-1:0] exc_pc
);
  localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_EXEC, S_RESP} st_t;
  st_t st;

  logic [2:0]      op_q;
  logic [TAGW-1:0] dst_q, src_tag_q;
  logic [XLEN-1:0] opnd_q, res_val_q;
  logic            opnd_rdy, zsrc_q, pc_seen, res_exc_q;
  logic [11:0]     addr_q;
  logic [ROBW-1:0] rob_q;

  wire imm_form = issue_op[2];
  wire [1:0] kind = op_q[1:0];

  logic            wants_write, cnt_sel, cnt_ok, illegal;
  logic [XLEN-1:0] new_val;

  always_comb begin
    wants_write = (kind == 2'b01) || (kind != 2'b00 && !zsrc_q);
    case (kind)
      2'b10:   new_val = csr_rdata | opnd_q;
      2'b11:   new_val = csr_rdata & ~opnd_q;
      default: new_val = opnd_q;
    endcase
    cnt_sel = (addr_q[11:1] == 11'h600);
    cnt_ok  = (priv == 2'd3) ||
              (cnt_m_en[addr_q[0]] && (priv != 2'd0 || cnt_s_en[addr_q[0]]));
    illegal = (kind == 2'b00) || !csr_present || (addr_q[9:8] > priv) ||
              (wants_write && addr_q[11:10] == 2'b11) || (cnt_sel && !cnt_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= '0;
      dst_q     <= '0;
      src_tag_q <= '0;
      opnd_q    <= '0;
      opnd_rdy  <= 1'b0;
      zsrc_q    <= 1'b0;
      pc_seen   <= 1'b0;
      addr_q    <= '0;
      rob_q     <= '0;
      res_val_q <= '0;
      res_exc_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (issue_valid) begin
          op_q      <= issue_op;
          dst_q     <= issue_dst_tag;
          src_tag_q <= issue_src_tag;
          addr_q    <= issue_addr;
          rob_q     <= issue_rob;
          opnd_q    <= imm_form ? {{(XLEN-5){1'b0}}, issue_imm} : issue_src_val;
          opnd_rdy  <= imm_form || (issue_src_tag == '0);
          zsrc_q    <= imm_form ? (issue_imm == 5'd0) : (issue_rs1_idx == 5'd0);
          pc_seen   <= 1'b0;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (!opnd_rdy && bcast_valid && bcast_tag == src_tag_q) begin
            opnd_q   <= bcast_val;
            opnd_rdy <= 1'b1;
          end
          if (precommit_valid && precommit_rob == rob_q) pc_seen <= 1'b1;
          if (opnd_rdy && pc_seen) st <= S_EXEC;
        end
        S_EXEC: begin
          res_val_q <= illegal ? '0 : csr_rdata;
          res_exc_q <= illegal;
          st        <= S_RESP;
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end

  assign issue_ready = (st == S_IDLE);
  assign csr_addr    = addr_q;
  assign csr_wdata   = new_val;
  assign csr_we      = (st == S_EXEC) && wants_write && !illegal;
  assign exc_valid   = (st == S_EXEC) && illegal;
  assign exc_rob     = rob_q;
  assign exc_cause   = CAUSE_ILLEGAL;
  assign exc_pc      = '0;
  assign res_valid   = (st == S_RESP);
  assign res_dst_tag = dst_q;
  assign res_value   = res_val_q;
  assign res_exc     = res_exc_q;
endmodule

// File: rtl/csr_exec_unit_chk.sv
module csr_exec_unit_chk #(
  parameter int XLEN = 32,
  parameter int TAGW = 4,
  parameter int ROBW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic            issue_ready,
  input logic [ROBW-1:0] issue_rob,
  input logic            precommit_valid,
  input logic [ROBW-1:0] precommit_rob,
  input logic [1:0]      priv,
  input logic [11:0]     csr_addr,
  input logic            csr_present,
  input logic            csr_we,
  input logic            res_valid,
  input logic            res_ready,
  input logic [XLEN-1:0] res_value,
  input logic            res_exc,
  input logic            exc_valid,
  input logic [ROBW-1:0] exc_rob,
  input logic [3:0]      exc_cause,
  input logic [XLEN-1:0] exc_pc
);
  logic [ROBW-1:0] rob_c;
  logic            seen_c;
  wire fire = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_c  <= '0;
      seen_c <= 1'b0;
    end else if (fire) begin
      rob_c  <= issue_rob;
      seen_c <= 1'b0;
    end else if (precommit_valid && precommit_rob == rob_c) begin
      seen_c <= 1'b1;
    end
  end

  p_we_after_precommit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> seen_c);
  p_no_write_on_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && exc_valid));
  p_exc_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == 4'd2 && exc_pc == '0 && exc_rob == rob_c && seen_c));
  p_ro_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> csr_addr[11:10] != 2'b11);
  p_present_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> csr_present);
  p_priv_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> csr_addr[9:8] <= priv);
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_exc)));
  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !issue_ready);
endmodule

bind csr_exec_unit csr_exec_unit_chk #(.XLEN(XLEN), .TAGW(TAGW), .ROBW(ROBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_rob(issue_rob), .precommit_valid(precommit_valid), .precommit_rob(precommit_rob),
  .priv(priv), .csr_addr(csr_addr), .csr_present(csr_present), .csr_we(csr_we),
  .res_valid(res_valid), .res_ready(res_ready), .res_value(res_value), .res_exc(res_exc),
  .exc_valid(exc_valid), .exc_rob(exc_rob), .exc_cause(exc_cause), .exc_pc(exc_pc)
);

// File: tb/csr_exec_unit_test.sv
`timescale 1ns/1ps
module csr_exec_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        issue_valid = 0, issue_ready;
  logic [2:0]  issue_op = 0;
  logic [3:0]  issue_dst_tag = 0, issue_src_tag = 0;
  logic [31:0] issue_src_val = 0;
  logic [4:0]  issue_rs1_idx = 0, issue_imm = 0;
  logic [11:0] issue_addr = 0;
  logic [4:0]  issue_rob = 0;
  logic        bcast_valid = 0;
  logic [3:0]  bcast_tag = 0;
  logic [31:0] bcast_val = 0;
  logic        precommit_valid = 0;
  logic [4:0]  precommit_rob = 0;
  logic [1:0]  priv = 2'd3, cnt_m_en = 0, cnt_s_en = 0;
  logic [11:0] csr_addr;
  logic        csr_present, csr_we;
  logic [31:0] csr_rdata, csr_wdata;
  logic        res_valid, res_ready = 0, res_exc, exc_valid;
  logic [3:0]  res_dst_tag, exc_cause;
  logic [31:0] res_value, exc_pc;
  logic [4:0]  exc_rob;

  csr_exec_unit uut (.*);

  logic [31:0] m340, m100, m7fe, mcc0, mc00, mc01;
  always_comb begin
    csr_present = 1'b1;
    case (csr_addr)
      12'h340: csr_rdata = m340;
      12'h100: csr_rdata = m100;
      12'h7FE: csr_rdata = m7fe;
      12'hCC0: csr_rdata = mcc0;
      12'hC00: csr_rdata = mc00;
      12'hC01: csr_rdata = mc01;
      default: begin csr_rdata = 32'h0; csr_present = 1'b0; end
    endcase
  end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m340 <= 32'h0000_00F0; m100 <= 32'hAAAA_5555; m7fe <= 32'h1111_2222;
      mcc0 <= 32'hCAFE_0000; mc00 <= 32'h0000_1000; mc01 <= 32'h0000_2000;
    end else if (csr_we) begin
      case (csr_addr)
        12'h340: m340 <= csr_wdata;
        12'h100: m100 <= csr_wdata;
        12'h7FE: m7fe <= csr_wdata;
        12'hCC0: mcc0 <= csr_wdata;
        12'hC00: mc00 <= csr_wdata;
        12'hC01: mc01 <= csr_wdata;
        default: ;
      endcase
    end
  end

  int exc_cnt = 0;
  logic [4:0]  last_rob;
  logic [3:0]  last_cause;
  logic [31:0] last_pc;
  always @(posedge clk) if (rst_n && exc_valid) begin
    exc_cnt++; last_rob = exc_rob; last_cause = exc_cause; last_pc = exc_pc;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] r_val;
  logic        r_exc;
  logic [3:0]  r_dst;

  task automatic run(input logic [2:0] op, input logic [3:0] dst, input logic [3:0] stag,
                     input logic [31:0] sval, input logic [4:0] rs1, input logic [4:0] imm,
                     input logic [11:0] addr, input logic [4:0] rob);
    logic [191:0] snap;
    int n;
    snap = {m340, m100, m7fe, mcc0, mc00, mc01};
    @(negedge clk);
    issue_valid = 1; issue_op = op; issue_dst_tag = dst; issue_src_tag = stag;
    issue_src_val = (stag != 0) ? 32'hBAD0_BAD0 : sval;
    issue_rs1_idx = rs1; issue_imm = imm; issue_addr = addr; issue_rob = rob;
    @(negedge clk);
    issue_valid = 0;
    chk("R12 busy after accept", {31'd0, issue_ready}, 32'd0);
    if (stag != 0) begin
      bcast_valid = 1; bcast_tag = stag + 4'd1; bcast_val = 32'h5A5A_5A5A;
      @(negedge clk);
      bcast_tag = stag; bcast_val = sval;
      @(negedge clk);
      bcast_valid = 0;
    end
    precommit_valid = 1; precommit_rob = rob + 5'd1;
    @(negedge clk);
    precommit_valid = 0;
    repeat (3) @(negedge clk);
    chk("R6 no write before precommit", {31'd0, ({m340, m100, m7fe, mcc0, mc00, mc01} == snap)}, 32'd1);
    chk("R6 no result before precommit", {31'd0, res_valid}, 32'd0);
    precommit_valid = 1; precommit_rob = rob;
    @(negedge clk);
    precommit_valid = 0;
    n = 0;
    while (!res_valid && n < 20) begin @(negedge clk); n++; end
    r_val = res_value; r_exc = res_exc; r_dst = res_dst_tag;
    @(negedge clk);
    chk("R4 result held until taken", {31'd0, res_valid}, 32'd1);
    chk("R4 value stable", res_value, r_val);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk("R12 ready after result taken", {31'd0, issue_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R12 reset ready", {31'd0, issue_ready}, 32'd1);
    chk("R4 reset no result", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_rw;
    int e0 = exc_cnt;
    priv = 2'd3;
    run(3'd1, 4'd5, 4'd0, 32'hDEAD_BEEF, 5'd9, 5'd0, 12'h340, 5'd1);
    chk("R4 old value", r_val, 32'h0000_00F0);
    chk("R4 dst tag", {28'd0, r_dst}, 32'd5);
    chk("R1 read-write stores operand", m340, 32'hDEAD_BEEF);
    chk("R11 legal no exc flag", {31'd0, r_exc}, 32'd0);
    chk("R11 legal no exc pulse", exc_cnt - e0, 32'd0);
  endtask

  task automatic t_bcast;
    run(3'd2, 4'd6, 4'd3, 32'h0000_0F00, 5'd7, 5'd0, 12'h340, 5'd2);
    chk("R5 old value", r_val, 32'hDEAD_BEEF);
    chk("R5 operand from matching broadcast (R1 set)", m340, 32'hDEAD_BFEF);
  endtask

  task automatic t_clear;
    run(3'd3, 4'd7, 4'd0, 32'hFFFF_0000, 5'd4, 5'd0, 12'h340, 5'd3);
    chk("R1 read-clear old", r_val, 32'hDEAD_BFEF);
    chk("R1 read-clear stores and-not", m340, 32'h0000_BFEF);
  endtask

  task automatic t_imm;
    run(3'd5, 4'd1, 4'd0, 32'hFFFF_FFFF, 5'd3, 5'h1F, 12'h340, 5'd4);
    chk("R2 immediate zero-extended, source ignored", m340, 32'h0000_001F);
    run(3'd7, 4'd1, 4'd0, 32'hFFFF_FFFF, 5'd3, 5'h03, 12'h340, 5'd5);
    chk("R1 clear immediate", m340, 32'h0000_001C);
    run(3'd6, 4'd1, 4'd0, 32'hFFFF_FFFF, 5'd3, 5'h01, 12'h340, 5'd6);
    chk("R1 set immediate", m340, 32'h0000_001D);
    chk("R2 set immediate old", r_val, 32'h0000_001C);
  endtask

  task automatic t_nowrite;
    run(3'd2, 4'd2, 4'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, 12'h340, 5'd7);
    chk("R3 set with index 0 returns old", r_val, 32'h0000_001D);
    chk("R3 set with index 0 keeps value", m340, 32'h0000_001D);
    run(3'd3, 4'd2, 4'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, 12'h340, 5'd8);
    chk("R3 clear with index 0 keeps value", m340, 32'h0000_001D);
    run(3'd7, 4'd2, 4'd0, 32'hFFFF_FFFF, 5'd9, 5'd0, 12'h340, 5'd9);
    chk("R3 clear immediate 0 keeps value", m340, 32'h0000_001D);
  endtask

  task automatic t_exc(input string req, input logic [4:0] rob, input logic [2:0] op,
                       input logic [4:0] rs1, input logic [11:0] addr);
    int e0 = exc_cnt;
    run(op, 4'd2, 4'd0, 32'h0000_0001, rs1, 5'd0, addr, rob);
    chk({req, " exc flag"}, {31'd0, r_exc}, 32'd1);
    chk({req, " value zero"}, r_val, 32'd0);
    chk("R11 one exc pulse", exc_cnt - e0, 32'd1);
    chk("R11 exc rob", {27'd0, last_rob}, {27'd0, rob});
    chk("R11 exc cause", {28'd0, last_cause}, 32'd2);
    chk("R11 exc pc", last_pc, 32'd0);
  endtask

  task automatic t_legal(input string req, input logic [4:0] rob, input logic [11:0] addr,
                         input logic [31:0] exp);
    int e0 = exc_cnt;
    run(3'd2, 4'd2, 4'd0, 32'h0, 5'd0, 5'd0, addr, rob);
    chk({req, " no exc"}, {31'd0, r_exc}, 32'd0);
    chk({req, " read value"}, r_val, exp);
    chk({req, " no exc pulse"}, exc_cnt - e0, 32'd0);
  endtask

  task automatic t_access;
    priv = 2'd3;
    t_exc("R7 write read-only", 5'd10, 3'd1, 5'd1, 12'hCC0);
    chk("R7 read-only value kept", mcc0, 32'hCAFE_0000);
    t_legal("R7 read of read-only", 5'd11, 12'hCC0, 32'hCAFE_0000);
    t_exc("R8 absent address", 5'd12, 3'd2, 5'd0, 12'hFFF);
    priv = 2'd0;
    t_exc("R9 user to machine csr", 5'd13, 3'd1, 5'd1, 12'h7FE);
    chk("R9 machine csr kept", m7fe, 32'h1111_2222);
    priv = 2'd3;
    t_legal("R9 machine reads machine csr", 5'd14, 12'h7FE, 32'h1111_2222);
    priv = 2'd1;
    run(3'd1, 4'd3, 4'd0, 32'h0000_0042, 5'd1, 5'd0, 12'h100, 5'd15);
    chk("R9 supervisor writes supervisor csr", m100, 32'h0000_0042);
  endtask

  task automatic t_counters;
    priv = 2'd1; cnt_m_en = 2'b00; cnt_s_en = 2'b11;
    t_exc("R10 supervisor cycle without machine enable", 5'd16, 3'd2, 5'd0, 12'hC00);
    priv = 2'd0; cnt_m_en = 2'b10; cnt_s_en = 2'b00;
    t_exc("R10 user time without supervisor enable", 5'd17, 3'd2, 5'd0, 12'hC01);
    priv = 2'd0; cnt_m_en = 2'b01; cnt_s_en = 2'b01;
    t_legal("R10 user cycle both enables", 5'd18, 12'hC00, 32'h0000_1000);
    priv = 2'd3; cnt_m_en = 2'b00; cnt_s_en = 2'b00;
    t_legal("R10 machine cycle no enables", 5'd19, 12'hC00, 32'h0000_1000);
    priv = 2'd1; cnt_m_en = 2'b10; cnt_s_en = 2'b00;
    t_legal("R10 supervisor time machine enable", 5'd20, 12'hC01, 32'h0000_2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_bcast();
    t_clear();
    t_imm();
    t_nowrite();
    t_access();
    t_counters();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule